// File: doc/BRIEF.md
# Read Return Latency and Byte Mask Pipeline

This block sits on the read return path of a synchronous, SDRAM-style memory. Each cycle it takes the command that the front end registered (a READ, a BURST TERMINATE or an ACTIVE TERMINATE), a burst-continue flag from the column address generator, and the array word fetched for that beat. It delays each beat so that it appears at the data outputs a programmed number of cycles after its request. Per-byte output enables follow a read mask that has a fixed two-cycle delay of its own.

The latency is held in a small mode register. A load is taken only while the caller reports that all banks are idle and the word holds a legal setting. A load that is not taken leaves the current setting in place and raises a one-cycle error pulse.

A terminate stops new beats at once. Beats that are already in flight still come out, so the outputs go quiet no later than one latency period after the terminate.

Top module: `rd_return_pipe`

## Requirements
- R1: After reset, `dq_valid`, `dq_oe` and `load_err` are 0 and the latency is 2 cycles.
- R2: A beat requested at clock edge n with latency L (1, 2 or 3) is presented on `dq_out` with `dq_valid` high from edge n+L-1 until edge n+L. It is therefore valid at edge n+L.
- R3: The latency is taken from mode word bits [6:4]: 3'b001 gives 1, 3'b010 gives 2 and 3'b011 gives 3. Any other code is rejected: `load_err` pulses for one cycle after the load edge and the previous latency stays.
- R4: A load whose operating-mode bits [8:7] are not 2'b00 is rejected in the same way as an illegal latency code.
- R5: A load presented while `banks_idle` is 0 is ignored, and `load_err` is 1 for exactly the cycle after that edge.
- R6: Each edge where `burst_live` is high after a READ, with no terminate since that READ, adds one beat. These beats leave in consecutive cycles. `burst_live` before the first READ has no effect.
- R7: A READ may arrive on any cycle, including in the middle of a burst, and its beats follow the earlier beats with no gap.
- R8: `dqm[0]` high at edge n turns lane 0 (`dq_out[7:0]`) off from edge n+1 until edge n+2. `dqm[1]` does the same for lane 1 (`dq_out[15:8]`). A lane that is off has its `dq_oe` bit at 0 and reads 0 on `dq_out`.
- R9: `bt_cmd` or `at_cmd` at edge n adds no beat at n and makes `burst_live` ignored until the next READ. Beats that were requested before edge n still come out.
- R10: With no beat in flight, `dq_valid` and both `dq_oe` bits are 0 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Request to load the mode word |
| mode_word | input | 12 | Mode word; latency code in [6:4], operating mode in [8:7] |
| banks_idle | input | 1 | All banks idle; loads are taken only when this is 1 |
| rd_cmd | input | 1 | Registered READ command, which starts a burst |
| bt_cmd | input | 1 | Registered BURST TERMINATE |
| at_cmd | input | 1 | Registered ACTIVE TERMINATE |
| burst_live | input | 1 | Address generator requests the next beat of the burst |
| arr_data | input | 16 | Array word for the beat requested this cycle |
| dqm | input | 2 | Read mask per byte lane, 1 = turn that lane off |
| dq_out | output | 16 | Returned data; a lane that is off reads 0 |
| dq_oe | output | 2 | Output enable per byte lane |
| dq_valid | output | 1 | A beat is being presented this cycle |
| load_err | output | 1 | One-cycle pulse after a mode load that was rejected |

## Verification
The hardest case to reach is the interaction of the two independent delays. The mask has a fixed two-cycle delay while the data delay is programmable, so a mask bit that is sampled in the middle of a burst lands on a beat chosen by the latency setting, not on the beat that was requested with it. The stimulus table changes the mask on single cycles inside a burst that is extended by a second READ and then cut by a terminate. Directed runs then reprogram the latency to 1 and to 3 and drain a terminated burst at the longest setting.

// File: rtl/rdp_pkg.sv
// Shared constants and helpers for the read return pipeline.
// Assumes a 12-bit mode word with the latency code and operating-mode bits at fixed positions.
package rdp_pkg;
    localparam int MODE_W     = 12;
    localparam int LAT_LSB    = 4;
    localparam int OP_LSB     = 7;
    // Reset word: single-location writes, latency code 2, burst length code 8
    localparam logic [MODE_W-1:0] MODE_RST = 12'h223;

    // True when a three-bit latency code names a supported latency
    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction
endpackage

// File: rtl/rdp_mode_reg.sv
// Mode register holding the read latency.
// A load is taken only when all banks are idle and the word holds a legal setting; otherwise an error pulse is raised.
module rdp_mode_reg
    import rdp_pkg::*;
#(
    parameter int LAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    input  logic              idle,
    output logic [LAT_W-1:0]  lat,
    output logic              err
);
    logic [2:0] code;
    logic [1:0] opm;
    logic       accept;

    // Decode the load request against its acceptance rules
    always_comb begin
        code   = word[LAT_LSB +: 3];
        opm    = word[OP_LSB +: 2];
        accept = load && idle && lat_code_ok(code) && (opm == 2'b00);
    end

    // Hold the latency and flag rejected loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= LAT_W'(MODE_RST[LAT_LSB +: 3]);
            err <= 1'b0;
        end else begin
            err <= load && !accept;
            if (accept) begin
                lat <= LAT_W'(code);
            end
        end
    end
endmodule

// File: rtl/rdp_beat_pipe.sv
// Shift register of beats (valid flag and data), tapped at the stage that the latency selects.
// Assumes the latency does not change while beats are in flight.
module rdp_beat_pipe #(
    parameter int DW    = 16,
    parameter int DEPTH = 3,
    parameter int LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [DW-1:0]    in_data,
    input  logic [LAT_W-1:0] lat,
    output logic             out_vld,
    output logic [DW-1:0]    out_data
);
    logic [DEPTH-1:0] vld;
    logic [DW-1:0]    dat [DEPTH];

    // Stage 0 captures the beat on its request edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld[0] <= 1'b0;
            dat[0] <= '0;
        end else begin
            vld[0] <= in_vld;
            dat[0] <= in_vld ? in_data : '0;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Each later stage adds one cycle of delay
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                dat[g] <= '0;
            end else begin
                vld[g] <= vld[g-1];
                dat[g] <= dat[g-1];
            end
        end
    end

    // Select the stage that matches the programmed latency
    always_comb begin
        out_vld  = 1'b0;
        out_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (lat == LAT_W'(k + 1)) begin
                out_vld  = vld[k];
                out_data = dat[k];
            end
        end
    end
endmodule

// File: rtl/rdp_lane_mask.sv
// Fixed-delay pipeline for the per-lane read mask.
// Assumes DELAY is at least 1.
module rdp_lane_mask #(
    parameter int LANES = 2,
    parameter int DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_out
);
    logic [LANES-1:0] sh [DELAY];

    // First stage samples the mask pins
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= '0;
        else        sh[0] <= mask_in;
    end

    for (genvar g = 1; g < DELAY; g++) begin : g_dly
        // Later stages carry the mask forward
        always_ff @(posedge clk) begin
            if (!rst_n) sh[g] <= '0;
            else        sh[g] <= sh[g-1];
        end
    end

    assign mask_out = sh[DELAY-1];
endmodule

// File: rtl/rd_return_pipe.sv
// Read return path: programmable data latency, fixed mask delay, burst cut on terminate.
// Assumes at most one of rd_cmd, bt_cmd and at_cmd is high in any cycle.
module rd_return_pipe
    import rdp_pkg::*;
#(
    parameter int DW       = 16,
    parameter int MAX_LAT  = 3,
    parameter int MASK_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              banks_idle,
    input  logic              rd_cmd,
    input  logic              bt_cmd,
    input  logic              at_cmd,
    input  logic              burst_live,
    input  logic [DW-1:0]     arr_data,
    input  logic [DW/8-1:0]   dqm,
    output logic [DW-1:0]     dq_out,
    output logic [DW/8-1:0]   dq_oe,
    output logic              dq_valid,
    output logic              load_err
);
    localparam int LANES = DW / 8;
    localparam int LAT_W = $clog2(MAX_LAT + 1);

    logic [LAT_W-1:0] lat_q;
    logic             cut_q;
    logic             term;
    logic             beat_req;
    logic             pipe_vld;
    logic [DW-1:0]    pipe_data;
    logic [LANES-1:0] mask_q;

    rdp_mode_reg #(.LAT_W(LAT_W)) mode_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mode_load),
        .word (mode_word),
        .idle (banks_idle),
        .lat  (lat_q),
        .err  (load_err)
    );

    // Combine the command and burst flag into a beat request
    always_comb begin
        term     = bt_cmd || at_cmd;
        beat_req = rd_cmd || (burst_live && !cut_q && !term);
    end

    // Track whether the current burst has been cut; no burst exists before the first READ
    always_ff @(posedge clk) begin
        if (!rst_n)      cut_q <= 1'b1;
        else if (rd_cmd) cut_q <= 1'b0;
        else if (term)   cut_q <= 1'b1;
    end

    rdp_beat_pipe #(.DW(DW), .DEPTH(MAX_LAT), .LAT_W(LAT_W)) pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (beat_req),
        .in_data (arr_data),
        .lat     (lat_q),
        .out_vld (pipe_vld),
        .out_data(pipe_data)
    );

    rdp_lane_mask #(.LANES(LANES), .DELAY(MASK_DLY)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_in (dqm),
        .mask_out(mask_q)
    );

    assign dq_valid = pipe_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Drive a lane only when a beat is present and the lane is not masked
        always_comb begin
            dq_oe[l]         = pipe_vld && !mask_q[l];
            dq_out[8*l +: 8] = dq_oe[l] ? pipe_data[8*l +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/rdp_checker.sv
// Checker for the read return pipeline, attached with a bind.
// Assumes the latency is not reloaded while a beat is in flight.
module rdp_checker #(
    parameter int MAX_LAT = 3,
    parameter int LANES   = 2,
    parameter int LAT_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_cmd,
    input logic             bt_cmd,
    input logic             at_cmd,
    input logic [LANES-1:0] dqm,
    input logic [LANES-1:0] dq_oe,
    input logic             dq_valid,
    input logic             mode_load,
    input logic             load_err,
    input logic [LAT_W-1:0] lat
);
    localparam int RUN_W = $clog2(MAX_LAT + 3);

    logic [1:0]       age;
    logic [RUN_W-1:0] idle_run;

    // Count the edges since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    // Count the cycles since a terminate with no READ after it
    always_ff @(posedge clk) begin
        if (!rst_n)                                        idle_run <= '0;
        else if (rd_cmd)                                   idle_run <= '0;
        else if (bt_cmd || at_cmd)                         idle_run <= RUN_W'(1);
        else if (idle_run != 0 && idle_run != {RUN_W{1'b1}}) idle_run <= idle_run + RUN_W'(1);
    end

    // R2
    lat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && lat == LAT_W'(1)) |=> dq_valid);
    // R2
    lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && lat == LAT_W'(2)) |-> ##2 dq_valid);
    // R2
    lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && lat == LAT_W'(3)) |-> ##3 dq_valid);
    // R5
    load_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> $past(mode_load));
    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_run > RUN_W'(MAX_LAT)) |-> (dq_oe == '0 && !dq_valid));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R8
        mask_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && $past(dqm[l], 2)) |-> !dq_oe[l]);
    end
endmodule

bind rd_return_pipe rdp_checker #(
    .MAX_LAT(MAX_LAT),
    .LANES  (LANES),
    .LAT_W  (LAT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .bt_cmd   (bt_cmd),
    .at_cmd   (at_cmd),
    .dqm      (dqm),
    .dq_oe    (dq_oe),
    .dq_valid (dq_valid),
    .mode_load(mode_load),
    .load_err (load_err),
    .lat      (lat_q)
);

// File: tb/rd_return_pipe_tb_top.sv
// Bench for rd_return_pipe: a table walk at latency 2, then directed latency, mode load and drain cases.
module rd_return_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_load;
    logic [11:0] mode_word;
    logic        banks_idle;
    logic        rd_cmd, bt_cmd, at_cmd, burst_live;
    logic [15:0] arr_data;
    logic [1:0]  dqm;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        dq_valid;
    logic        load_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rd_return_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .banks_idle(banks_idle), .rd_cmd(rd_cmd), .bt_cmd(bt_cmd), .at_cmd(at_cmd),
        .burst_live(burst_live), .arr_data(arr_data), .dqm(dqm),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid), .load_err(load_err)
    );

    typedef struct packed {
        logic        rd, bt, at, bl;
        logic [1:0]  m;
        logic [15:0] d;
        logic        ev;
        logic [1:0]  eo;
        logic [15:0] eq;
    } vec_t;

    // One entry per cycle at latency 2; expected outputs are those seen after that entry's edge
    localparam vec_t VEC [12] = '{
        '{1'b1,1'b0,1'b0,1'b0, 2'b00, 16'h1111, 1'b0, 2'b00, 16'h0000}, // R2 read captured
        '{1'b0,1'b0,1'b0,1'b1, 2'b00, 16'h2222, 1'b1, 2'b11, 16'h1111}, // R2 first beat
        '{1'b0,1'b0,1'b0,1'b1, 2'b01, 16'h3333, 1'b1, 2'b11, 16'h2222}, // R6 mask sampled
        '{1'b0,1'b0,1'b0,1'b1, 2'b00, 16'h4444, 1'b1, 2'b10, 16'h3300}, // R8 lane 0 off
        '{1'b1,1'b0,1'b0,1'b0, 2'b10, 16'h5555, 1'b1, 2'b11, 16'h4444}, // R7 new read
        '{1'b0,1'b0,1'b0,1'b1, 2'b00, 16'h6666, 1'b1, 2'b01, 16'h0055}, // R8 lane 1 off
        '{1'b0,1'b1,1'b0,1'b1, 2'b00, 16'h7777, 1'b1, 2'b11, 16'h6666}, // R9 burst terminate
        '{1'b0,1'b0,1'b0,1'b1, 2'b00, 16'h8888, 1'b0, 2'b00, 16'h0000}, // R9 burst cut
        '{1'b0,1'b0,1'b0,1'b0, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000}, // R10 idle
        '{1'b1,1'b0,1'b0,1'b0, 2'b00, 16'h9999, 1'b0, 2'b00, 16'h0000}, // R2 read
        '{1'b0,1'b0,1'b1,1'b1, 2'b00, 16'hAAAA, 1'b1, 2'b11, 16'h9999}, // R9 active terminate
        '{1'b0,1'b0,1'b0,1'b0, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0000}  // R10 quiet
    };

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one edge and settle at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Return every input to its idle value
    task automatic idle_in();
        mode_load = 1'b0; mode_word = 12'h000; banks_idle = 1'b1;
        rd_cmd = 1'b0; bt_cmd = 1'b0; at_cmd = 1'b0; burst_live = 1'b0;
        arr_data = 16'h0000; dqm = 2'b00;
    endtask

    // Issue a single read and count the edges until its data is valid
    task automatic measure_lat(input string tag, input int exp_lat, input logic [15:0] d);
        int k;
        rd_cmd = 1'b1; arr_data = d;
        tick();
        idle_in();
        k = 1;
        while (!dq_valid && k < 6) begin
            tick();
            k++;
        end
        chk({tag, " latency"}, 32'(k), 32'(exp_lat));
        chk({tag, " data"}, {16'h0, dq_out}, {16'h0, d});
        repeat (4) tick();
    endtask

    // Present a mode load for one edge and check the error pulse and its end
    task automatic load_mode(input string tag, input logic [11:0] w, input logic idle, input logic exp_err);
        mode_load = 1'b1; mode_word = w; banks_idle = idle;
        tick();
        idle_in();
        chk({tag, " load_err"}, 32'(load_err), 32'(exp_err));
        tick();
        chk({tag, " load_err end"}, 32'(load_err), 32'(0));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 dq_valid", 32'(dq_valid), 0);
        chk("R1 dq_oe", 32'(dq_oe), 0);
        chk("R1 load_err", 32'(load_err), 0);

        // R6: burst_live before any READ adds no beat
        burst_live = 1'b1; arr_data = 16'hDEAD;
        repeat (4) begin
            tick();
            chk("R6 no read yet", {15'h0, dq_valid, dq_out}, 32'h0);
        end
        idle_in();

        // R1: default latency is 2
        measure_lat("R1", 2, 16'hC0DE);

        // Table walk at latency 2 (R2, R6, R7, R8, R9, R10)
        for (int i = 0; i < 12; i++) begin
            rd_cmd = VEC[i].rd; bt_cmd = VEC[i].bt; at_cmd = VEC[i].at;
            burst_live = VEC[i].bl; dqm = VEC[i].m; arr_data = VEC[i].d;
            tick();
            chk($sformatf("R2/R6-R10 vec %0d", i),
                {13'h0, VEC[i].ev, VEC[i].eo, VEC[i].eq} ^ 32'h0 ^ {13'h0, dq_valid, dq_oe, dq_out} ^ {13'h0, VEC[i].ev, VEC[i].eo, VEC[i].eq},
                {13'h0, VEC[i].ev, VEC[i].eo, VEC[i].eq});
        end
        idle_in();
        repeat (3) tick();

        // R3, R2: latency 1 and latency 3
        load_mode("R3 lat1", 12'h210, 1'b1, 1'b0);
        measure_lat("R2 lat1", 1, 16'h0101);
        load_mode("R3 lat3", 12'h230, 1'b1, 1'b0);
        measure_lat("R2 lat3", 3, 16'h0303);

        // R3: reserved latency code is rejected
        load_mode("R3 reserved", 12'h240, 1'b1, 1'b1);
        measure_lat("R3 kept", 3, 16'h0404);

        // R4: non-zero operating mode is rejected
        load_mode("R4 opmode", 12'h2A0, 1'b1, 1'b1);
        measure_lat("R4 kept", 3, 16'h0505);

        // R5: load while banks are busy is ignored
        load_mode("R5 busy", 12'h210, 1'b0, 1'b1);
        measure_lat("R5 kept", 3, 16'h0606);

        // R9: terminate at latency 3 drains the beats already requested
        rd_cmd = 1'b1; arr_data = 16'hA001;
        tick();
        chk("R9 drain e1", 32'(dq_valid), 0);
        idle_in(); burst_live = 1'b1; arr_data = 16'hA002;
        tick();
        chk("R9 drain e2", 32'(dq_valid), 0);
        arr_data = 16'hA003;
        tick();
        chk("R9 drain beat1", {15'h0, dq_valid, dq_out}, {15'h0, 1'b1, 16'hA001});
        bt_cmd = 1'b1; arr_data = 16'hA004;
        tick();
        chk("R9 drain beat2", {15'h0, dq_valid, dq_out}, {15'h0, 1'b1, 16'hA002});
        bt_cmd = 1'b0; arr_data = 16'hA005;
        tick();
        chk("R9 drain beat3", {15'h0, dq_valid, dq_out}, {15'h0, 1'b1, 16'hA003});
        tick();
        chk("R9 drained", {14'h0, dq_valid, dq_oe, dq_out}, 32'h0);
        tick();
        chk("R10 stays off", {14'h0, dq_valid, dq_oe, dq_out}, 32'h0);
        idle_in();
        repeat (2) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule